// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character per request into a framed asynchronous bit stream on a single line. A frame is a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. Three format inputs pick the frame at run time: data length (7 or 8 bits), parity on or off, and one or two stop bits. A fourth input picks even or odd parity. The chosen format is captured when a character is accepted, so the format can change between frames but not during one.

Bit timing comes from a tick at 16 times the bit rate. A source-select input chooses where that tick comes from. It can come from an internal reloadable divider on the system clock, or from an external clock input. The external input is synchronized with two flops, and each of its rising edges counts as one tick. When the internal divider is in use, the block drives a clock output at the 16x rate. Characters enter through a valid/ready handshake, which is ready only while the line is idle. A busy flag covers the whole frame.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset and between frames, txd_o is high, busy_o is low and ready_o is high.
- R2: A frame is one start bit at 0, then the data bits from bit 0 upward, then the parity bit if enabled, then the stop bit or bits at 1.
- R3: len7_i=1 sends 7 data bits (data_i[6:0]) and bit 7 of data_i has no effect. len7_i=0 sends 8 data bits.
- R4: par_en_i=1 adds a parity bit right after the data. With par_odd_i=0 it makes the count of ones in the sent data plus parity even. With par_odd_i=1 it makes that count odd.
- R5: stop2_i=1 sends two stop bits and stop2_i=0 sends one. The frame length is 9 to 12 bit periods.
- R6: With ext_sel_i=0, every bit lasts 16*(div_i+1) clock cycles, counted from the accepting edge. busy_o falls exactly frame_bits*16*(div_i+1) cycles after that edge.
- R7: With ext_sel_i=1, each rising edge of ext_clk_i, after a two-flop synchronizer, is one tick. Each bit lasts 16 periods of ext_clk_i.
- R8: With ext_sel_i=0 and div_i>=1, clk16_o has exactly one rising edge every div_i+1 cycles. With ext_sel_i=1, clk16_o stays 0.
- R9: A character is accepted only when valid_i and ready_o are both 1. valid_i asserted during a frame has no effect, on the current frame or later.
- R10: The format inputs and data_i are captured at acceptance. Changing them during a frame does not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Character to send |
| valid_i | input | 1 | Character request |
| ready_o | output | 1 | Block idle and able to accept |
| len7_i | input | 1 | 1: 7 data bits, 0: 8 data bits |
| par_en_i | input | 1 | 1: append a parity bit |
| par_odd_i | input | 1 | 0: even parity, 1: odd parity |
| stop2_i | input | 1 | 1: two stop bits, 0: one |
| ext_sel_i | input | 1 | 1: tick from ext_clk_i, 0: internal divider |
| ext_clk_i | input | 1 | External 16x bit-rate clock |
| div_i | input | DIV_W | Divider reload; tick every div_i+1 cycles |
| busy_o | output | 1 | Frame in progress |
| txd_o | output | 1 | Serial line |
| clk16_o | output | 1 | 16x clock output in internal mode |

## Verification
The hardest case to reach from the ports is a request, or a format change, that arrives while a frame is still being sent. Only that case shows whether the block captured its inputs at the start bit. For every frame the bench therefore pulses valid_i with the inverted character right after acceptance. It also inverts all four format inputs for the rest of the frame. It then checks each sampled bit against the format that was originally requested, and checks that no second frame follows. The sweep covers all eight formats with both parity senses and several data values, including one where only bit 7 is set. It runs in both tick-source modes.

// File: rtl/sft_pkg.sv
package sft_pkg;
  localparam int FRAME_MAX = 12;

  typedef struct packed {
    logic len7;
    logic par_en;
    logic par_odd;
    logic stop2;
  } fmt_t;

  function automatic logic [3:0] frame_len(fmt_t f);
    return 4'd9 + (f.len7 ? 4'd0 : 4'd1) + (f.par_en ? 4'd1 : 4'd0) + (f.stop2 ? 4'd1 : 4'd0);
  endfunction

  // bit 0 goes out first; unused tail positions stay at the stop level
  function automatic logic [FRAME_MAX-1:0] build_frame(logic [7:0] d, fmt_t f);
    logic [FRAME_MAX-1:0] fr;
    logic [7:0] m;
    logic p;
    fr = '1;
    fr[0] = 1'b0;
    m = f.len7 ? (d & 8'h7F) : d;
    for (int i = 0; i < 8; i++)
      if (i < 7 || !f.len7) fr[1+i] = m[i];
    p = (^m) ^ f.par_odd;
    if (f.par_en) begin
      if (f.len7) fr[8] = p;
      else        fr[9] = p;
    end
    return fr;
  endfunction
endpackage

// File: rtl/sft_tick_gen.sv
module sft_tick_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_sel_i,
  input  logic             ext_clk_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o,
  output logic             clk16_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [1:0]       sync_q;
  logic             ext_prev_q;
  logic             int_tick, ext_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      sync_q     <= '0;
      ext_prev_q <= 1'b0;
    end else begin
      sync_q     <= {sync_q[0], ext_clk_i};
      ext_prev_q <= sync_q[1];
      if (restart_i || cnt_q == '0) cnt_q <= div_i;
      else                          cnt_q <= cnt_q - 1'b1;
    end
  end

  // restart realigns bit phase to the accepting edge
  assign int_tick = (cnt_q == '0) && !restart_i;
  assign ext_tick = sync_q[1] && !ext_prev_q;
  assign tick_o   = ext_sel_i ? ext_tick : int_tick;
  assign clk16_o  = !ext_sel_i && (cnt_q > (div_i >> 1));

  // R7 R6
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && (ext_sel_i || div_i != '0)) |=> (!tick_o || ext_sel_i != $past(ext_sel_i)));
endmodule

// File: rtl/sft_serializer.sv
module sft_serializer
  import sft_pkg::*;
#(
  parameter int OVS = 16,
  localparam int CW = $clog2(OVS)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [7:0] data_i,
  input  fmt_t       fmt_i,
  output logic       active_o,
  output logic       txd_o
);
  logic                 active_q;
  logic [FRAME_MAX-1:0] shreg_q;
  logic [CW-1:0]        os_q;
  logic [3:0]           bit_q, nbits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      shreg_q  <= '1;
      os_q     <= '0;
      bit_q    <= '0;
      nbits_q  <= 4'd9;
    end else if (start_i) begin
      active_q <= 1'b1;
      shreg_q  <= build_frame(data_i, fmt_i);
      os_q     <= '0;
      bit_q    <= '0;
      nbits_q  <= frame_len(fmt_i);
    end else if (active_q && tick_i) begin
      if (os_q == CW'(OVS - 1)) begin
        os_q    <= '0;
        shreg_q <= {1'b1, shreg_q[FRAME_MAX-1:1]};
        if (bit_q == nbits_q - 4'd1) active_q <= 1'b0;
        else                         bit_q    <= bit_q + 4'd1;
      end else begin
        os_q <= os_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign txd_o    = shreg_q[0];

  // R5
  bit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (bit_q < nbits_q && nbits_q >= 4'd9 && nbits_q <= 4'd12));
  // R10
  fmt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !start_i) |=> $stable(nbits_q));
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sft_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int OVS   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       data_i,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic             len7_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic             stop2_i,
  input  logic             ext_sel_i,
  input  logic             ext_clk_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             busy_o,
  output logic             txd_o,
  output logic             clk16_o
);
  logic tick, active, accept;
  fmt_t fmt;

  assign fmt     = '{len7: len7_i, par_en: par_en_i, par_odd: par_odd_i, stop2: stop2_i};
  assign ready_o = !active;
  assign busy_o  = active;
  assign accept  = valid_i && ready_o;

  sft_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .ext_sel_i, .ext_clk_i, .div_i,
    .restart_i(accept), .tick_o(tick), .clk16_o
  );

  sft_serializer #(.OVS(OVS)) u_ser (
    .clk_i, .rst_ni, .tick_i(tick), .start_i(accept),
    .data_i, .fmt_i(fmt), .active_o(active), .txd_o
  );

  // R1
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> txd_o);
  // R2
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (busy_o && !txd_o));
  // R9
  no_reaccept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(txd_o) || $past(tick));
endmodule

// File: tb/tb_serial_frame_tx.sv
module tb_serial_frame_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] data = '0;
  logic valid = 0, len7 = 0, pen = 0, podd = 0, st2 = 0, esel = 0;
  logic [11:0] div = 12'd2;
  logic [1:0] ecnt = '0;
  logic ready, busy, txd, clk16;
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) begin cyc <= cyc + 1; ecnt <= ecnt + 2'd1; end

  serial_frame_tx dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid), .ready_o(ready),
    .len7_i(len7), .par_en_i(pen), .par_odd_i(podd), .stop2_i(st2),
    .ext_sel_i(esel), .ext_clk_i(ecnt[1]), .div_i(div),
    .busy_o(busy), .txd_o(txd), .clk16_o(clk16)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic logic [11:0] exp_frame(logic [7:0] d, logic l7, logic pe, logic po);
    logic [11:0] f = '1;
    int dl = l7 ? 7 : 8;
    logic p = 1'b0;
    f[0] = 1'b0;
    for (int i = 0; i < dl; i++) begin f[1+i] = d[i]; p ^= d[i]; end
    if (pe) f[1+dl] = p ^ po;
    return f;
  endfunction

  // P: bit period in cycles; exact: internal-mode timing is cycle exact
  task automatic send(logic [7:0] d, logic [2:0] fm, logic po, int P, bit exact);
    int t, n;
    logic [11:0] got, exp;
    @(negedge clk);
    data = d; len7 = fm[2]; pen = fm[1]; st2 = fm[0]; podd = po; valid = 1;
    @(negedge clk);
    t = cyc;
    // R9 R10: request and format change mid-frame
    data = ~d; len7 = ~fm[2]; pen = ~fm[1]; st2 = ~fm[0]; podd = ~po;
    repeat (3) @(negedge clk);
    valid = 0;
    n = 9 + (fm[2] ? 0 : 1) + (fm[1] ? 1 : 0) + (fm[0] ? 1 : 0);
    exp = exp_frame(d, fm[2], fm[1], po);
    got = '1;
    for (int k = 0; k < n; k++) begin
      wait_cyc(t + k * P + P / 2);
      got[k] = txd;
    end
    // R2 R3 R4 R5 R10
    chk(got == exp, "R2/R3/R4/R5/R10 frame", got, exp);
    if (exact) begin
      wait_cyc(t + n * P - 1);
      chk(busy, "R6 busy before end", busy, 1);
      wait_cyc(t + n * P);
      chk(!busy && ready && txd, "R6 end of frame", {busy, ready, txd}, 3'b011);
    end else begin
      wait_cyc(t + n * P - 12);
      chk(busy, "R7 busy before end", busy, 1);
      wait_cyc(t + n * P + 8);
      chk(!busy, "R7 end of frame", busy, 0);
    end
    repeat (6) @(negedge clk);
    // R9: the mid-frame request did not start another frame
    chk(!busy && txd && ready, "R9 R1 idle after frame", {busy, txd, ready}, 3'b011);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] vals [4] = '{8'h80, 8'h3C, 8'hA5, 8'h7F};
    int r;
    logic prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(txd && !busy && ready, "R1 reset state", {txd, busy, ready}, 3'b101);

    // R8 internal clock output, div=2
    r = 0; prev = clk16;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (clk16 && !prev) r++;
      prev = clk16;
    end
    chk(r >= 99 && r <= 101, "R8 clk16 rate", r, 100);

    // R2..R6, R9, R10: all formats, both parities, several values
    for (int f = 0; f < 8; f++)
      for (int po = 0; po < 2; po++)
        foreach (vals[v]) send(vals[v], 3'(f), 1'(po), 48, 1);

    // R6 with another divider
    div = 12'd4;
    send(8'h96, 3'b010, 1'b1, 80, 1);

    // R7 external tick, R8 output held low
    esel = 1;
    r = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (clk16) r++; end
    chk(r == 0, "R8 clk16 low in external mode", r, 0);
    for (int f = 0; f < 8; f++) send(8'hC3, 3'(f), f[0], 64, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule